// File: doc/BRIEF.md
# Configurable UART Framing Transceiver

A full-duplex asynchronous serial transceiver that turns bytes into framed serial characters on `txd` and recovers characters from `rxd`. The frame shape is chosen by three control inputs: a two-bit parity mode, a character-length select (7 or 8 data bits) and a transmit stop-bit select (one or two). Bit timing comes from an externally generated baud tick that runs at a fixed multiple of the bit rate. The block does not divide a clock to make that tick, and it does not decode registers or route interrupts.

Each direction has its own enable, and both are qualified by a shared power enable. An enable is taken into the base-clock domain through a registered gate. When an enable drops, the gate holds its section in reset for a minimum number of base clocks. The gate captures the frame format only while the section is off, so a format change made while running waits for the next enable. The receiver reports each character with a one-cycle strobe and a held ready flag that `rx_rd` clears. It also reports parity, framing and overrun errors, and pulses an error interrupt when any of them is present.

Top module: `uart_frame_xcvr`

## Requirements
- R1: After reset, `txd` is 1, `tx_busy` is 0, `rx_ready` is 0 and all three error flags are 0.
- R2: A transmitted frame is one start bit of 0, then the data bits LSB first (7 bits when `chr8`=0, 8 bits when `chr8`=1), then the optional parity bit, then stop bits of 1. There is one stop bit when `stop_two`=0 and two when `stop_two`=1. Each bit lasts OVS baud ticks.
- R3: `par_sel` sets the parity bit for both directions. 2'b00 sends no parity bit. 2'b01 sends a parity bit fixed at 0. 2'b10 sends odd parity, which makes the count of ones across the data and parity bits odd. 2'b11 sends even parity.
- R4: The receiver assembles the data bits LSB first and outputs them on `rx_data` with bit 7 at 0 in 7-bit mode. It pulses `rx_strobe` for one cycle and holds `rx_ready` at 1 until `rx_rd` is pulsed.
- R5: In odd and even modes a received parity bit that does not match sets `err_parity` and pulses `err_irq`. In the 2'b01 mode the parity bit is accepted without any check and never sets `err_parity`.
- R6: `err_frame` is set when the single sampled stop bit is 0. The receiver checks only one stop bit whatever `stop_two` is, so characters sent back to back with one stop bit are all received.
- R7: A character that completes while `rx_ready` is still 1 sets `err_overrun` and pulses `err_irq`. The new data replaces `rx_data`. The error flags describe the most recent character.
- R8: A section runs only when `pwr_en` and its own enable are both 1. Dropping either enable mid-frame abandons the frame: `txd` returns to 1 and `tx_busy` to 0 within two clocks, and the receiver ignores the line.
- R9: A `tx_wr` presented in the same clock as the rising transmit enable is ignored. A write one clock later or after is accepted and starts a frame.
- R10: After an enable is cleared, its section stays in reset for at least HOLD base clocks even if the enable returns at once, and writes in that window are ignored.
- R11: If the receiver is enabled while `rxd` is already low, that low is taken as a start bit and the character is received.
- R12: The format inputs are captured only while a section is disabled. Changes made while it is enabled do not affect its frames until it is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_en | input | 1 | Shared power enable for both sections |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| par_sel | input | 2 | Parity mode: 00 none, 01 fixed zero, 10 odd, 11 even |
| chr8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| stop_two | input | 1 | 1 = two transmit stop bits, 0 = one |
| baud_tick | input | 1 | Oversampling tick, OVS per bit |
| tx_wr | input | 1 | Write strobe for transmit data |
| tx_data | input | 8 | Transmit character |
| tx_busy | output | 1 | A character is pending or being sent |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |
| rx_rd | input | 1 | Read acknowledge, clears rx_ready |
| rx_data | output | 8 | Last received character |
| rx_strobe | output | 1 | One-cycle pulse per received character |
| rx_ready | output | 1 | Unread character held |
| err_parity | output | 1 | Parity mismatch on last character |
| err_frame | output | 1 | Stop bit sampled as 0 on last character |
| err_overrun | output | 1 | Last character overwrote an unread one |
| err_irq | output | 1 | One-cycle pulse when a character has any error |

## Verification
The bound checker watches rules that must hold on every cycle. It checks that `txd` stays high while the transmitter is held off and that a dropped section never comes back on the next clock. It checks that `err_parity` never appears in the fixed-zero mode and that every error interrupt has a flag behind it. It also checks that each strobe comes with `rx_ready` set, that a frame starts only from an enabled section, and that the latched format stays unchanged while a section runs. Only the directed scenarios can show the exact bit order and parity values on the wire, the ignored write on the enabling clock, the reset window after a quick re-enable, reception that begins from a line already low, and overrun across two unread characters.

// File: rtl/uart_fx_pkg.sv
package uart_fx_pkg;

   localparam int unsigned MAX_DATA = 8;
   localparam int unsigned FRM_W    = 1 + MAX_DATA + 1 + 2;

   localparam logic [1:0] PAR_NONE = 2'b00;
   localparam logic [1:0] PAR_ZERO = 2'b01;
   localparam logic [1:0] PAR_ODD  = 2'b10;
   localparam logic [1:0] PAR_EVEN = 2'b11;

   typedef struct packed {
      logic par;
      logic frm;
      logic ovr;
   } rx_err_t;

   // parity bit for a character, masked to the selected length
   function automatic logic par_bit(input logic [1:0] mode, input logic c8,
                                    input logic [MAX_DATA-1:0] d);
      logic [MAX_DATA-1:0] m;
      m = c8 ? d : {1'b0, d[MAX_DATA-2:0]};
      case (mode)
         PAR_ODD:  par_bit = ~^m;
         PAR_EVEN: par_bit = ^m;
         default:  par_bit = 1'b0;
      endcase
   endfunction

   // whole frame, bit 0 first on the wire; unused upper bits are idle ones
   function automatic logic [FRM_W-1:0] frame_bits(input logic [1:0] mode,
                                                   input logic c8,
                                                   input logic [MAX_DATA-1:0] d);
      logic [FRM_W-1:0] f;
      f    = '1;
      f[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++)
         if (i < MAX_DATA - 1 || c8) f[i+1] = d[i];
      if (mode != PAR_NONE) begin
         if (c8) f[MAX_DATA+1] = par_bit(mode, c8, d);
         else    f[MAX_DATA]   = par_bit(mode, c8, d);
      end
      frame_bits = f;
   endfunction

   function automatic logic [3:0] frame_len(input logic [1:0] mode,
                                            input logic c8, input logic s2);
      frame_len = 4'd1 + (c8 ? 4'd8 : 4'd7) + ((mode != PAR_NONE) ? 4'd1 : 4'd0)
                + (s2 ? 4'd2 : 4'd1);
   endfunction

endpackage

// File: rtl/uart_fx_gate.sv
module uart_fx_gate #(
   parameter int unsigned HOLD = 2,
   parameter int unsigned CFG_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_en,
   input  logic             sec_en,
   input  logic [CFG_W-1:0] cfg_in,
   output logic             active,
   output logic [CFG_W-1:0] cfg_q
);
   localparam int unsigned CW = $clog2(HOLD + 1);

   generate
      if (HOLD < 2) begin : g_bad_hold
         $error("uart_fx_gate: HOLD must be at least 2");
      end
   endgenerate

   logic [CW-1:0] off_cnt;
   logic          req;

   assign req = pwr_en & sec_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         off_cnt <= CW'(HOLD);
         cfg_q   <= '0;
      end else begin
         if (!active) cfg_q <= cfg_in;
         if (active) begin
            if (!req) begin
               active  <= 1'b0;
               off_cnt <= '0;
            end
         end else if (off_cnt != CW'(HOLD)) begin
            off_cnt <= off_cnt + 1'b1;
         end else if (req) begin
            active <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/uart_fx_tx.sv
module uart_fx_tx
   import uart_fx_pkg::*;
#(
   parameter int unsigned OVS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                act,
   input  logic [1:0]          par,
   input  logic                c8,
   input  logic                s2,
   input  logic                tick,
   input  logic                wr,
   input  logic [MAX_DATA-1:0] wdata,
   output logic                txd,
   output logic                busy
);
   localparam int unsigned CW = $clog2(OVS);

   logic [FRM_W-1:0]    sr;
   logic [3:0]          left;
   logic [CW-1:0]       tcnt;
   logic                pend;
   logic [MAX_DATA-1:0] hold;
   logic [FRM_W-1:0]    frm_w;
   logic [3:0]          nb_w;

   assign frm_w = frame_bits(par, c8, hold);
   assign nb_w  = frame_len(par, c8, s2);
   assign busy  = pend | (left != 4'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txd  <= 1'b1;
         sr   <= '1;
         left <= '0;
         tcnt <= '0;
         pend <= 1'b0;
         hold <= '0;
      end else if (!act) begin
         txd  <= 1'b1;
         sr   <= '1;
         left <= '0;
         tcnt <= '0;
         pend <= 1'b0;
      end else begin
         if (wr && !busy) begin
            hold <= wdata;
            pend <= 1'b1;
         end
         if (left == 4'd0) begin
            if (pend) begin
               txd  <= frm_w[0];
               sr   <= {1'b1, frm_w[FRM_W-1:1]};
               left <= nb_w;
               tcnt <= '0;
               pend <= 1'b0;
            end
         end else if (tick) begin
            if (tcnt == CW'(OVS - 1)) begin
               tcnt <= '0;
               left <= left - 4'd1;
               if (left > 4'd1) begin
                  txd <= sr[0];
                  sr  <= {1'b1, sr[FRM_W-1:1]};
               end else begin
                  txd <= 1'b1;
               end
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/uart_fx_rx.sv
module uart_fx_rx
   import uart_fx_pkg::*;
#(
   parameter int unsigned OVS  = 16,
   parameter int unsigned SYNC = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                act,
   input  logic [1:0]          par,
   input  logic                c8,
   input  logic                tick,
   input  logic                rxd,
   input  logic                rd,
   output logic [MAX_DATA-1:0] rx_data,
   output logic                ready,
   output logic                strobe,
   output rx_err_t             err,
   output logic                irq
);
   localparam int unsigned CW   = $clog2(OVS);
   localparam int unsigned HALF = OVS / 2;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_st_e;

   logic [SYNC-1:0]     sy;
   logic                rxs;
   rx_st_e              st;
   logic [CW-1:0]       tcnt;
   logic [3:0]          idx;
   logic [MAX_DATA-1:0] sh;
   logic                pbit;
   logic [3:0]          dlen;
   logic                haspar;
   logic                perr_w;
   logic                ovr_w;

   generate
      if (SYNC < 2) begin : g_bad_sync
         $error("uart_fx_rx: SYNC must be at least 2");
      end
      if (SYNC == 2) begin : g_sync2
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sy <= '1;
            else        sy <= {sy[0], rxd};
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sy <= '1;
            else        sy <= {sy[SYNC-2:0], rxd};
      end
   endgenerate

   assign rxs    = sy[SYNC-1];
   assign dlen   = c8 ? 4'd8 : 4'd7;
   assign haspar = (par != PAR_NONE);
   assign perr_w = par[1] && (pbit != par_bit(par, c8, sh));
   assign ovr_w  = ready && !rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         tcnt    <= '0;
         idx     <= '0;
         sh      <= '0;
         pbit    <= 1'b0;
         rx_data <= '0;
         ready   <= 1'b0;
         strobe  <= 1'b0;
         err     <= '0;
         irq     <= 1'b0;
      end else begin
         strobe <= 1'b0;
         irq    <= 1'b0;
         if (!act) begin
            st    <= RX_IDLE;
            tcnt  <= '0;
            ready <= 1'b0;
            err   <= '0;
         end else begin
            if (rd) ready <= 1'b0;
            case (st)
               RX_IDLE: begin
                  if (!rxs) begin
                     st   <= RX_START;
                     tcnt <= '0;
                  end
               end
               RX_START: begin
                  if (tick) begin
                     if (tcnt == CW'(HALF - 1)) begin
                        tcnt <= '0;
                        if (!rxs) begin
                           st  <= RX_BITS;
                           idx <= '0;
                           sh  <= '0;
                        end else begin
                           st <= RX_IDLE;
                        end
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               RX_BITS: begin
                  if (tick) begin
                     if (tcnt == CW'(OVS - 1)) begin
                        tcnt <= '0;
                        idx  <= idx + 4'd1;
                        if (idx < dlen) begin
                           sh[idx[2:0]] <= rxs;
                        end else if (idx == dlen && haspar) begin
                           pbit <= rxs;
                        end else begin
                           st      <= RX_IDLE;
                           rx_data <= sh;
                           strobe  <= 1'b1;
                           ready   <= 1'b1;
                           err.frm <= !rxs;
                           err.par <= perr_w;
                           err.ovr <= ovr_w;
                           irq     <= !rxs | perr_w | ovr_w;
                        end
                     end else begin
                        tcnt <= tcnt + 1'b1;
                     end
                  end
               end
               default: st <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_frame_xcvr.sv
module uart_frame_xcvr
   import uart_fx_pkg::*;
#(
   parameter int unsigned OVS  = 16,
   parameter int unsigned SYNC = 2,
   parameter int unsigned HOLD = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwr_en,
   input  logic       tx_en,
   input  logic       rx_en,
   input  logic [1:0] par_sel,
   input  logic       chr8,
   input  logic       stop_two,
   input  logic       baud_tick,
   input  logic       tx_wr,
   input  logic [7:0] tx_data,
   output logic       tx_busy,
   output logic       txd,
   input  logic       rxd,
   input  logic       rx_rd,
   output logic [7:0] rx_data,
   output logic       rx_strobe,
   output logic       rx_ready,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_overrun,
   output logic       err_irq
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_frame_xcvr: OVS must be even and at least 4");
      end
   endgenerate

   logic       tx_act;
   logic       rx_act;
   logic [3:0] tx_cfg;
   logic [2:0] rx_cfg;
   logic [1:0] rx_par_l;
   rx_err_t    rx_err;

   uart_fx_gate #(.HOLD(HOLD), .CFG_W(4)) u_tx_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_en (pwr_en),
      .sec_en (tx_en),
      .cfg_in ({par_sel, chr8, stop_two}),
      .active (tx_act),
      .cfg_q  (tx_cfg)
   );

   uart_fx_gate #(.HOLD(HOLD), .CFG_W(3)) u_rx_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .pwr_en (pwr_en),
      .sec_en (rx_en),
      .cfg_in ({par_sel, chr8}),
      .active (rx_act),
      .cfg_q  (rx_cfg)
   );

   assign rx_par_l = rx_cfg[2:1];

   uart_fx_tx #(.OVS(OVS)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (tx_act),
      .par   (tx_cfg[3:2]),
      .c8    (tx_cfg[1]),
      .s2    (tx_cfg[0]),
      .tick  (baud_tick),
      .wr    (tx_wr),
      .wdata (tx_data),
      .txd   (txd),
      .busy  (tx_busy)
   );

   uart_fx_rx #(.OVS(OVS), .SYNC(SYNC)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .act     (rx_act),
      .par     (rx_cfg[2:1]),
      .c8      (rx_cfg[0]),
      .tick    (baud_tick),
      .rxd     (rxd),
      .rd      (rx_rd),
      .rx_data (rx_data),
      .ready   (rx_ready),
      .strobe  (rx_strobe),
      .err     (rx_err),
      .irq     (err_irq)
   );

   assign err_parity  = rx_err.par;
   assign err_frame   = rx_err.frm;
   assign err_overrun = rx_err.ovr;

endmodule

// File: rtl/uart_frame_xcvr_chk.sv
module uart_frame_xcvr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_act,
   input logic       rx_act,
   input logic       txd,
   input logic       tx_busy,
   input logic [3:0] tx_cfg,
   input logic [1:0] rx_par_l,
   input logic       rx_strobe,
   input logic       rx_ready,
   input logic       err_parity,
   input logic       err_frame,
   input logic       err_overrun,
   input logic       err_irq
);
   // R8
   txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_act && !$past(tx_act)) |-> txd);

   // R10
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_act) |=> !tx_act);

   // R10
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rx_act) |=> !rx_act);

   // R5
   zero_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_parity |-> rx_par_l[1]);

   // R7
   irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_irq |-> (err_parity || err_frame || err_overrun));

   // R4
   strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_strobe |-> rx_ready);

   // R9
   tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_busy) |-> $past(tx_act));

   // R12
   fmt_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_act && $past(tx_act)) |-> $stable(tx_cfg));

endmodule

bind uart_frame_xcvr uart_frame_xcvr_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_act      (tx_act),
   .rx_act      (rx_act),
   .txd         (txd),
   .tx_busy     (tx_busy),
   .tx_cfg      (tx_cfg),
   .rx_par_l    (rx_par_l),
   .rx_strobe   (rx_strobe),
   .rx_ready    (rx_ready),
   .err_parity  (err_parity),
   .err_frame   (err_frame),
   .err_overrun (err_overrun),
   .err_irq     (err_irq)
);

// File: tb/uart_frame_xcvr_tb.sv
module uart_frame_xcvr_tb;
   localparam int OVS = 16;
   localparam int TDIV = 2;
   localparam int BIT = OVS * TDIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_en = 1'b0, tx_en = 1'b0, rx_en = 1'b0;
   logic [1:0] par_sel = 2'b00;
   logic       chr8 = 1'b1, stop_two = 1'b0;
   logic       baud_tick = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_busy, txd;
   logic       rxd = 1'b1;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_data;
   logic       rx_strobe, rx_ready, err_parity, err_frame, err_overrun, err_irq;

   int n_run = 0;
   int n_fail = 0;
   int irq_n = 0;
   int stb_n = 0;
   bit done = 0;

   always #4 clk = ~clk;

   always @(negedge clk) baud_tick <= ~baud_tick;
   always @(negedge clk) begin
      if (err_irq) irq_n++;
      if (rx_strobe) stb_n++;
   end

   uart_frame_xcvr #(.OVS(OVS)) u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .tx_en(tx_en), .rx_en(rx_en),
      .par_sel(par_sel), .chr8(chr8), .stop_two(stop_two), .baud_tick(baud_tick),
      .tx_wr(tx_wr), .tx_data(tx_data), .tx_busy(tx_busy), .txd(txd), .rxd(rxd),
      .rx_rd(rx_rd), .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_ready(rx_ready),
      .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
      .err_irq(err_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clocks(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic exp_par(input logic [1:0] p, input logic c8, input logic [7:0] d);
      int ones = 0;
      for (int i = 0; i < 8; i++) if (i < 7 || c8) ones += d[i];
      if (p == 2'b10) return (ones % 2 == 0);
      if (p == 2'b11) return (ones % 2 == 1);
      return 1'b0;
   endfunction

   function automatic int exp_len(input logic [1:0] p, input logic c8, input logic s2);
      return 1 + (c8 ? 8 : 7) + (p != 2'b00 ? 1 : 0) + (s2 ? 2 : 1);
   endfunction

   function automatic logic [11:0] exp_frame(input logic [1:0] p, input logic c8, input logic [7:0] d);
      logic [11:0] f = '1;
      int k = 1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++) if (i < 7 || c8) begin f[k] = d[i]; k++; end
      if (p != 2'b00) f[k] = exp_par(p, c8, d);
      return f;
   endfunction

   // write one character and capture n bits from txd at mid-bit
   task automatic tx_capture(input logic [7:0] d, input int n, output logic [11:0] got);
      int t = 0;
      got = '1;
      tx_data = d; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
      while (txd !== 1'b0 && t < 200) begin @(negedge clk); t++; end
      clocks(BIT / 2);
      for (int i = 0; i < n; i++) begin
         got[i] = txd;
         clocks(BIT);
      end
   endtask

   task automatic tx_cfg(input logic [1:0] p, input logic c8, input logic s2);
      tx_en = 1'b0; clocks(4);
      par_sel = p; chr8 = c8; stop_two = s2;
      tx_en = 1'b1; clocks(2);
   endtask

   task automatic rx_cfg(input logic [1:0] p, input logic c8);
      rx_en = 1'b0; clocks(4);
      par_sel = p; chr8 = c8;
      rx_en = 1'b1; clocks(2);
   endtask

   task automatic rx_send(input logic [7:0] d, input logic [1:0] p, input logic c8,
                          input logic stopv, input logic badp, input logic skip_start);
      if (!skip_start) begin rxd = 1'b0; clocks(BIT); end
      for (int i = 0; i < 8; i++) if (i < 7 || c8) begin rxd = d[i]; clocks(BIT); end
      if (p != 2'b00) begin rxd = exp_par(p, c8, d) ^ badp; clocks(BIT); end
      rxd = stopv; clocks(BIT);
      rxd = 1'b1;
   endtask

   task automatic pulse_rd();
      rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0; @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 txd", txd, 1); chk("R1 tx_busy", tx_busy, 0);
      chk("R1 rx_ready", rx_ready, 0);
      chk("R1 errors", {err_parity, err_frame, err_overrun}, 0);
   endtask

   task automatic t_tx_8n1();
      logic [11:0] g;
      tx_cfg(2'b00, 1'b1, 1'b0);
      tx_capture(8'hA5, 10, g);
      chk("R2 8N1 frame", g[9:0], exp_frame(2'b00, 1'b1, 8'hA5) & 12'h3FF);
      clocks(BIT);
      chk("R2 idle after frame", {tx_busy, txd}, 2'b01);
   endtask

   task automatic t_tx_enable_edge();
      logic [11:0] g;
      int n;
      tx_en = 1'b0; clocks(6);
      par_sel = 2'b10; chr8 = 1'b0; stop_two = 1'b1;
      tx_en = 1'b1; tx_data = 8'h11; tx_wr = 1'b1;
      @(negedge clk); tx_wr = 1'b0;
      clocks(3);
      chk("R9 write on enabling clock ignored", {tx_busy, txd}, 2'b01);
      n = exp_len(2'b10, 1'b0, 1'b1);
      tx_capture(8'h53, n, g);
      chk("R2 R3 7O2 frame", g, exp_frame(2'b10, 1'b0, 8'h53));
      chk("R2 length 7O2", n, 11);
   endtask

   task automatic t_tx_even_zero();
      logic [11:0] g;
      tx_cfg(2'b11, 1'b1, 1'b0);
      tx_capture(8'h37, 11, g);
      chk("R3 even parity frame", g[10:0], exp_frame(2'b11, 1'b1, 8'h37) & 12'h7FF);
      clocks(BIT);
      tx_cfg(2'b01, 1'b1, 1'b0);
      tx_capture(8'hFF, 11, g);
      chk("R3 zero parity bit", g[9], 1'b0);
      chk("R3 zero parity frame", g[10:0], exp_frame(2'b01, 1'b1, 8'hFF) & 12'h7FF);
      clocks(BIT);
   endtask

   task automatic t_tx_fmt_lock();
      logic [11:0] g;
      tx_cfg(2'b00, 1'b1, 1'b0);
      par_sel = 2'b11; chr8 = 1'b0; stop_two = 1'b1;
      clocks(2);
      tx_capture(8'hC3, 10, g);
      chk("R12 format held while enabled", g[9:0], exp_frame(2'b00, 1'b1, 8'hC3) & 12'h3FF);
      clocks(BIT);
   endtask

   task automatic t_tx_reenable();
      logic low = 1'b0;
      tx_cfg(2'b00, 1'b1, 1'b0);
      tx_en = 1'b0; @(negedge clk);
      tx_en = 1'b1; tx_data = 8'h00; tx_wr = 1'b1;
      @(negedge clk);
      @(negedge clk); tx_wr = 1'b0;
      for (int i = 0; i < 8; i++) begin if (txd === 1'b0) low = 1'b1; @(negedge clk); end
      chk("R10 writes during reset window ignored", {tx_busy, low}, 2'b00);
   endtask

   task automatic t_tx_abort_power();
      logic low = 1'b0;
      tx_cfg(2'b00, 1'b1, 1'b0);
      tx_data = 8'h00; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
      clocks(3 * BIT);
      tx_en = 1'b0; clocks(2);
      chk("R8 frame abandoned", {tx_busy, txd}, 2'b01);
      pwr_en = 1'b0; clocks(4);
      tx_en = 1'b1; clocks(4);
      tx_data = 8'h00; tx_wr = 1'b1; @(negedge clk); tx_wr = 1'b0;
      for (int i = 0; i < 100; i++) begin if (txd === 1'b0) low = 1'b1; @(negedge clk); end
      chk("R8 power off blocks transmit", {tx_busy, low}, 2'b00);
      pwr_en = 1'b1; tx_en = 1'b0; clocks(4);
   endtask

   task automatic t_rx_basic();
      rx_cfg(2'b11, 1'b1);
      rx_send(8'h96, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0);
      clocks(4);
      chk("R4 rx data 8E1", rx_data, 8'h96);
      chk("R4 rx ready held", rx_ready, 1);
      chk("R5 no parity error", {err_parity, err_frame, err_overrun}, 0);
      chk("R4 one strobe", stb_n, 1);
      pulse_rd();
      chk("R4 ready cleared by read", rx_ready, 0);
   endtask

   task automatic t_rx_parity();
      int i0;
      rx_cfg(2'b10, 1'b1);
      i0 = irq_n;
      rx_send(8'h3C, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0);
      clocks(4);
      chk("R5 odd mismatch flagged", err_parity, 1);
      chk("R5 irq on parity", irq_n - i0, 1);
      pulse_rd();
      rx_cfg(2'b01, 1'b1);
      i0 = irq_n;
      rx_send(8'h3C, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0);
      clocks(4);
      chk("R5 zero mode data", rx_data, 8'h3C);
      chk("R5 zero mode unchecked", {err_parity, irq_n - i0}, 0);
      pulse_rd();
   endtask

   task automatic t_rx_frame();
      int s0;
      rx_cfg(2'b00, 1'b1);
      rx_send(8'h5A, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
      clocks(BIT);
      chk("R6 framing error", err_frame, 1);
      pulse_rd();
      stop_two = 1'b1;
      rx_cfg(2'b00, 1'b1);
      s0 = stb_n;
      rx_send(8'h81, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      pulse_rd();
      rx_send(8'h7E, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1 & 1'b0);
      clocks(4);
      chk("R6 back-to-back one stop bit", {stb_n - s0, rx_data, err_frame}, {24'd2, 8'h7E, 1'b0});
      pulse_rd();
   endtask

   task automatic t_rx_overrun();
      int i0;
      rx_cfg(2'b00, 1'b0);
      rx_send(8'hDA, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
      clocks(4);
      chk("R4 7-bit data", rx_data, 8'h5A);
      i0 = irq_n;
      rx_send(8'h21, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0);
      clocks(4);
      chk("R7 overrun flagged", {err_overrun, rx_data}, {1'b1, 8'h21});
      chk("R7 overrun irq", irq_n - i0, 1);
      pulse_rd();
   endtask

   task automatic t_rx_low_enable();
      rx_en = 1'b0; clocks(4);
      par_sel = 2'b00; chr8 = 1'b1;
      rxd = 1'b0; clocks(4);
      rx_en = 1'b1; clocks(BIT);
      rx_send(8'hC6, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1);
      clocks(4);
      chk("R11 start from low line", {rx_ready, rx_data}, {1'b1, 8'hC6});
      pulse_rd();
   endtask

   task automatic t_rx_power();
      int s0 = stb_n;
      pwr_en = 1'b0; clocks(4);
      rx_send(8'h44, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0);
      clocks(4);
      chk("R8 receiver off without power", {stb_n - s0, rx_ready}, 0);
      pwr_en = 1'b1;
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      end
   endtask

   initial begin
      clocks(3);
      t_reset();
      rst_n = 1'b1; clocks(2);
      t_reset();
      pwr_en = 1'b1;
      t_tx_8n1();
      t_tx_enable_edge();
      t_tx_even_zero();
      t_tx_fmt_lock();
      t_tx_reenable();
      t_tx_abort_power();
      t_rx_basic();
      t_rx_parity();
      t_rx_frame();
      t_rx_overrun();
      t_rx_low_enable();
      t_rx_power();
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

endmodule